// File: doc/BRIEF.md
# Byte-Wide SPI Port with Write-Collision Flag

This block is a full-duplex synchronous serial port that exchanges one byte per transfer. It can drive the serial clock as a master or follow an external clock as a slave. The host sees three byte-wide registers on a simple strobe bus: control, status and data. One data register serves both directions. A host write to it loads the internal shift register and, in master mode, starts the transfer. When the eighth bit has been exchanged, the byte that came in replaces the register contents, and a buffer-full bit and an interrupt flag are raised.

The internal shift register can only be reached through the data register. A write to the data register while a byte is still moving is dropped, and a sticky collision flag records it. The master clock is the system clock divided by 4, 16 or 64, or a timer tick input divided by two. In slave mode an active-low select input can gate the port, or it can be ignored.

The host bus has no back-pressure. Every strobe is taken in the cycle it is asserted. `bus_rdata` always shows the register selected by `bus_addr`, and only a read strobe on the data address has a side effect.

Top module: `spi_port`

## Requirements
- R1: A transfer exchanges exactly 8 bits, most significant bit first, sending the loaded byte on `sdo` while collecting the byte on `sdi`.
- R2: Registers are at `bus_addr` 0 = control ({collision flag bit 7, bit 6 reads 0, enable bit 5, polarity bit 4, mode bits 3:0}), 1 = status ({bits 7:3 zero, busy bit 2, interrupt flag bit 1, buffer-full bit 0}) and 2 = data. A data write while idle loads the shift register, and in a master mode it starts the transfer.
- R3: After the 8th bit the received byte appears in the data register, buffer-full and the interrupt flag are set, and `irq` follows the interrupt flag.
- R4: A read strobe on the data register clears buffer-full.
- R5: A data write while a transfer is in progress changes neither the data register nor the outgoing byte, and it sets the collision flag.
- R6: The collision flag stays set until a control write with bit 7 at 0 clears it.
- R7: The interrupt flag clears only on a status write with bit 1 at 0. A newly received byte overwrites an unread one.
- R8: In mode 4 (slave, select used), `ss_n` high resets the bit count, blocks shifting and holds `sdo`. In mode 5 (slave, select ignored) shifting takes place whatever `ss_n` is.
- R9: The idle SCK level equals the polarity bit. Data is sampled on the edge that leaves the idle level and changed on the edge that returns to it.
- R10: Modes 0, 1 and 2 are master modes with SCK half-periods of 2, 8 and 32 clock cycles. In mode 3, SCK toggles once per `tmr_tick` pulse.
- R11: With enable at 0 no transfer runs, `sck_o` sits at the polarity level and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe (acts on data address only) |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Selected register contents |
| irq | output | 1 | Interrupt flag |
| tmr_tick | input | 1 | External timer pulse for mode 3 |
| sck_o | output | 1 | Serial clock driven in master modes |
| sck_i | input | 1 | Serial clock received in slave modes |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| ss_n | input | 1 | Active-low slave select |

## Verification
The hardest situation to reach is a slave transfer that `ss_n` breaks off part-way. The stimulus first clocks a few bits in with select low, then raises select and checks that the port is idle again. It then clocks a complete fresh byte and expects exactly that byte, not a mix of the two. Collision is reached in master mode at the slowest divisor: a second data write is issued in the middle of the shift sequence, and the bench checks that the partner still receives the original byte. A bench-side partner model follows the SCK edges for each polarity and measures the half-period in every clock mode.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_DATA = 2'd2
  } reg_addr_e;

  typedef enum logic [3:0] {
    MODE_M_DIV_A = 4'd0,
    MODE_M_DIV_B = 4'd1,
    MODE_M_DIV_C = 4'd2,
    MODE_M_TIMER = 4'd3,
    MODE_S_GATED = 4'd4,
    MODE_S_FREE  = 4'd5
  } port_mode_e;

  localparam int CTRL_POL_BIT  = 4;
  localparam int CTRL_EN_BIT   = 5;
  localparam int CTRL_WCOL_BIT = 7;
  localparam int STAT_IRQ_BIT  = 1;
endpackage

// File: rtl/spi_clkgen.sv
module spi_clkgen
  import spi_port_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] mode,
  input  logic       tmr_tick,
  output logic       tgl
);
  localparam int HALF_MAX = DIV_C / 2;
  localparam int CW       = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          use_timer;

  always_comb begin
    case (mode)
      MODE_M_DIV_A: lim = CW'(DIV_A / 2 - 1);
      MODE_M_DIV_B: lim = CW'(DIV_B / 2 - 1);
      default:      lim = CW'(DIV_C / 2 - 1);
    endcase
  end

  assign use_timer = (mode == MODE_M_TIMER);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || cnt == lim) cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end

  assign tgl = run && (use_timer ? tmr_tick : (cnt == lim));

  // Internal divisors never give two toggles on back-to-back cycles
  p_half_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !use_timer && tgl && $stable(mode)) |=> !tgl);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              master,
  input  logic              ss_gate,
  input  logic              pol,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              m_tgl,
  input  logic              sck_i,
  input  logic              sdi,
  input  logic              ss_n,
  output logic              sck_o,
  output logic              sdo,
  output logic              run,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0]      sr;
  logic [CNT_W-1:0]       cnt;
  logic                   smp;
  logic                   sck_m;
  logic [SYNC_STAGES:0]   sck_pipe;
  logic [SYNC_STAGES-1:0] sdi_pipe;
  logic [SYNC_STAGES-1:0] ss_pipe;
  logic                   s_now, s_prev, s_lead, s_trail, ss_hi, ss_reset;
  logic                   lead, trail, sdi_x;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_pipe <= '0;
      sdi_pipe <= '0;
      ss_pipe  <= '1;
    end else begin
      sck_pipe <= {sck_pipe[SYNC_STAGES-1:0], sck_i};
      sdi_pipe <= {sdi_pipe[SYNC_STAGES-2:0], sdi};
      ss_pipe  <= {ss_pipe[SYNC_STAGES-2:0], ss_n};
    end
  end

  assign s_now    = sck_pipe[SYNC_STAGES-1];
  assign s_prev   = sck_pipe[SYNC_STAGES];
  assign s_lead   = (s_now != pol) && (s_prev == pol);
  assign s_trail  = (s_now == pol) && (s_prev != pol);
  assign ss_hi    = ss_pipe[SYNC_STAGES-1];
  assign ss_reset = !master && ss_gate && ss_hi;

  assign lead  = master ? (m_tgl && sck_m == pol) : (s_lead && !ss_reset);
  assign trail = master ? (m_tgl && sck_m != pol) : (s_trail && !ss_reset);
  assign sdi_x = master ? sdi : sdi_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr    <= '0;
      cnt   <= '0;
      smp   <= 1'b0;
      run   <= 1'b0;
      done  <= 1'b0;
      sck_m <= 1'b0;
    end else if (!en) begin
      cnt   <= '0;
      run   <= 1'b0;
      done  <= 1'b0;
      sck_m <= pol;
    end else begin
      done <= 1'b0;
      if (load) begin
        sr    <= load_data;
        cnt   <= '0;
        run   <= master;
        sck_m <= pol;
      end else if (ss_reset) begin
        cnt <= '0;
      end else begin
        if (lead) smp <= sdi_x;
        if (trail) begin
          sr <= {sr[DATA_W-2:0], smp};
          if (cnt == LAST) begin
            cnt  <= '0;
            done <= 1'b1;
            run  <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        if (!run)       sck_m <= pol;
        else if (m_tgl) sck_m <= ~sck_m;
      end
    end
  end

  assign sck_o   = (en && master) ? sck_m : pol;
  assign sdo     = sr[DATA_W-1];
  assign busy    = run || (cnt != '0) || done;
  assign rx_byte = sr;

  // A completed byte leaves the counter at zero and the master stopped
  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt == '0) && !run);

  // Deselected gated slave: count cleared, output bit frozen
  p_ss_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ss_reset && !load) |=> (cnt == '0) && $stable(sdo));

  // Disabled port keeps SCK at the idle level
  p_idle_sck_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (sck_o == pol) && !run);
endmodule

// File: rtl/spi_hostregs.sv
module spi_hostregs
  import spi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              busy,
  input  logic              done,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [3:0]        mode,
  output logic              pol,
  output logic              en,
  output logic              load,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq
);
  logic              wcol, bf, irqf;
  logic [BYTE_W-1:0] dbuf;
  logic              wr_ctrl, wr_stat, wr_data, rd_data;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_stat = bus_wr && (bus_addr == ADDR_STAT);
  assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
  assign rd_data = bus_rd && (bus_addr == ADDR_DATA);
  assign load    = wr_data && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0;
      pol  <= 1'b0;
      en   <= 1'b0;
      wcol <= 1'b0;
      bf   <= 1'b0;
      irqf <= 1'b0;
      dbuf <= '0;
    end else begin
      if (wr_ctrl) begin
        mode <= bus_wdata[3:0];
        pol  <= bus_wdata[CTRL_POL_BIT];
        en   <= bus_wdata[CTRL_EN_BIT];
      end
      if (wr_data && busy)  wcol <= 1'b1;
      else if (wr_ctrl)     wcol <= wcol && bus_wdata[CTRL_WCOL_BIT];

      if (done)             irqf <= 1'b1;
      else if (wr_stat)     irqf <= irqf && bus_wdata[STAT_IRQ_BIT];

      if (done)             bf <= 1'b1;
      else if (rd_data)     bf <= 1'b0;

      if (done)             dbuf <= rx_byte;
      else if (load)        dbuf <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_CTRL: bus_rdata = {wcol, 1'b0, en, pol, mode};
      ADDR_STAT: bus_rdata = {5'b0, busy, irqf, bf};
      ADDR_DATA: bus_rdata = dbuf;
      default:   bus_rdata = '0;
    endcase
  end

  assign irq = irqf;

  p_done_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> bf && irqf && (dbuf == $past(rx_byte)));

  p_bf_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !done) |=> !bf);

  p_collision_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && busy && !done) |=> wcol && $stable(dbuf));

  p_wcol_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wcol && !wr_ctrl) |=> wcol);

  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irqf && !wr_stat) |=> irqf);
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DIV_A       = 4,
  parameter int DIV_B       = 16,
  parameter int DIV_C       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              tmr_tick,
  output logic              sck_o,
  input  logic              sck_i,
  input  logic              sdi,
  output logic              sdo,
  input  logic              ss_n
);
  logic [3:0]        mode;
  logic              pol, en, load, master, ss_gate;
  logic              run, busy, done, m_tgl;
  logic [BYTE_W-1:0] rx_byte;

  assign master  = (mode <= MODE_M_TIMER);
  assign ss_gate = (mode == MODE_S_GATED);

  spi_hostregs u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .busy(busy), .done(done), .rx_byte(rx_byte),
    .mode(mode), .pol(pol), .en(en), .load(load),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  spi_clkgen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .mode(mode),
    .tmr_tick(tmr_tick), .tgl(m_tgl)
  );

  spi_shifter #(.DATA_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(en), .master(master), .ss_gate(ss_gate),
    .pol(pol), .load(load), .load_data(bus_wdata), .m_tgl(m_tgl),
    .sck_i(sck_i), .sdi(sdi), .ss_n(ss_n),
    .sck_o(sck_o), .sdo(sdo), .run(run), .busy(busy), .done(done),
    .rx_byte(rx_byte)
  );
endmodule

// File: tb/spi_port_tb.sv
`timescale 1ns/1ps
module spi_port_tb;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;
  localparam int VEC_N = 6;
  // {mode[31:28], pol[27:24], tx[23:16], partner byte[15:8], half period[7:0]}
  localparam logic [31:0] VEC [VEC_N] = '{
    {4'd0, 4'd0, 8'hA5, 8'h3C, 8'd2},
    {4'd1, 4'd1, 8'h81, 8'h7E, 8'd8},
    {4'd2, 4'd0, 8'hF0, 8'h0F, 8'd32},
    {4'd3, 4'd1, 8'h5A, 8'hC3, 8'd5},
    {4'd0, 4'd1, 8'h00, 8'hFF, 8'd2},
    {4'd1, 4'd0, 8'hFF, 8'h00, 8'd8}
  };

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic irq, tmr_tick, sck_o, sdo;
  logic sck_i = 0, sdi = 0, ss_n = 1;
  logic tick_on = 0;
  int   tick_cnt = 0;
  int   checks = 0, fails = 0;
  logic finished = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tick_cnt <= (tick_cnt == 4) ? 0 : tick_cnt + 1;
  end
  assign tmr_tick = tick_on && (tick_cnt == 4);

  spi_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .tmr_tick(tmr_tick), .sck_o(sck_o), .sck_i(sck_i),
    .sdi(sdi), .sdo(sdo), .ss_n(ss_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  // Partner for master modes: samples sdo on the edge leaving idle, shifts sdi on the return edge
  task automatic run_master(input logic p, input logic [7:0] sbyte, input int exp_half,
                            input int coll_at, output logic [7:0] got,
                            output logic half_ok, output logic fin);
    logic prev;
    logic [7:0] sl;
    int since, edges;
    got = 0; half_ok = 1; fin = 0; prev = sck_o; since = 0; edges = 0;
    sl = sbyte; sdi = sl[7];
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      since++;
      if (c == coll_at) begin bus_addr = A_DATA; bus_wdata = 8'h99; bus_wr = 1; end
      else bus_wr = 0;
      if (sck_o !== prev) begin
        if (edges > 0 && since != exp_half) half_ok = 0;
        edges++; since = 0; prev = sck_o;
        if (sck_o !== p) got = {got[6:0], sdo};
        else begin sl = {sl[6:0], 1'b0}; sdi = sl[7]; end
      end
      if (irq) begin fin = 1; break; end
    end
    bus_wr = 0;
  endtask

  // Bench acts as master toward a slave-mode port, half period of 6 clocks
  task automatic drive_slave(input logic p, input logic [7:0] b, input int nbits,
                             output logic [7:0] got);
    got = 0;
    for (int i = 0; i < nbits; i++) begin
      sdi = b[7 - i];
      repeat (6) @(negedge clk);
      sck_i = ~p; got = {got[6:0], sdo};
      repeat (6) @(negedge clk);
      sck_i = p;
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails + 1);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, got;
    logic ok, fin;
    int tog;
    logic prev;

    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // Reset state (R2, R9, R11)
    peek(A_STAT, d); chk("R2 reset status", d, 8'h00);
    peek(A_CTRL, d); chk("R2 reset control", d, 8'h00);
    chk("R3 reset irq", irq, 1'b0);
    chk("R9 reset sck idle", sck_o, 1'b0);

    // Master vectors: R1 R3 R4 R9 R10
    for (int v = 0; v < VEC_N; v++) begin
      logic [3:0] m; logic p; logic [7:0] tx, sb; int hh;
      m = VEC[v][31:28]; p = VEC[v][24]; tx = VEC[v][23:16];
      sb = VEC[v][15:8]; hh = int'(VEC[v][7:0]);
      tick_on = (m == 4'd3);
      wr(A_CTRL, {2'b00, 1'b1, p, m});
      wr(A_DATA, tx);
      run_master(p, sb, hh, -1, got, ok, fin);
      chk("R3 irq after byte", fin, 1'b1);
      peek(A_STAT, d); chk("R3 buffer-full set", d[0], 1'b1);
      rd(A_DATA, d);   chk("R1 received byte", d, sb);
      chk("R1 partner saw tx msb-first", got, tx);
      chk("R10 half period", ok, 1'b1);
      peek(A_STAT, d); chk("R4 bf cleared by read", d[0], 1'b0);
      chk("R9 idle level after transfer", sck_o, p);
      wr(A_STAT, 8'h00);
      tick_on = 0;
    end

    // Collision during a slow master transfer: R5, R6
    wr(A_CTRL, 8'h22);
    wr(A_DATA, 8'h3C);
    run_master(1'b0, 8'h96, 32, 100, got, ok, fin);
    peek(A_CTRL, d); chk("R5 collision flag set", d[7], 1'b1);
    rd(A_DATA, d);   chk("R5 data holds received byte", d, 8'h96);
    chk("R5 partner got original byte", got, 8'h3C);
    repeat (20) @(negedge clk);
    peek(A_CTRL, d); chk("R6 flag sticky after transfer", d[7], 1'b1);
    wr(A_CTRL, 8'hA2);
    peek(A_CTRL, d); chk("R6 write with bit7 set keeps flag", d[7], 1'b1);
    wr(A_CTRL, 8'h22);
    peek(A_CTRL, d); chk("R6 cleared by control write", d, 8'h22);

    // Interrupt flag and overwrite: R7
    chk("R7 irq still set", irq, 1'b1);
    wr(A_STAT, 8'h02); chk("R7 write of one keeps irq", irq, 1'b1);
    wr(A_STAT, 8'h00); chk("R7 write of zero clears irq", irq, 1'b0);
    wr(A_CTRL, 8'h20);
    wr(A_DATA, 8'h01);
    run_master(1'b0, 8'h11, 2, -1, got, ok, fin);
    wr(A_STAT, 8'h00);
    wr(A_DATA, 8'h02);
    run_master(1'b0, 8'h22, 2, -1, got, ok, fin);
    rd(A_DATA, d); chk("R7 unread byte overwritten", d, 8'h22);
    wr(A_STAT, 8'h00);

    // Gated slave: R8
    wr(A_CTRL, 8'h24);
    wr(A_DATA, 8'hAA);
    ss_n = 1; repeat (6) @(negedge clk);
    drive_slave(1'b0, 8'h55, 8, got);
    chk("R8 sdo held while deselected", got, 8'hFF);
    peek(A_STAT, d); chk("R8 no byte while deselected", d[1:0], 2'b00);
    ss_n = 0; repeat (6) @(negedge clk);
    drive_slave(1'b0, 8'h00, 3, got);
    peek(A_STAT, d); chk("R8 partial byte busy", d[2], 1'b1);
    ss_n = 1; repeat (6) @(negedge clk);
    peek(A_STAT, d); chk("R8 deselect resets count", d[2:0], 3'b000);
    ss_n = 0; repeat (6) @(negedge clk);
    drive_slave(1'b0, 8'hC6, 8, got);
    peek(A_STAT, d); chk("R8 full byte after reselect", d[1:0], 2'b11);
    rd(A_DATA, d); chk("R8 received fresh byte", d, 8'hC6);
    wr(A_STAT, 8'h00);

    // Ungated slave with polarity 1: R8, R9
    wr(A_CTRL, 8'h00);
    sck_i = 1; ss_n = 1; repeat (6) @(negedge clk);
    wr(A_CTRL, 8'h35);
    wr(A_DATA, 8'h3C);
    drive_slave(1'b1, 8'h99, 8, got);
    chk("R8 select ignored, sdo sequence", got, 8'h3C);
    rd(A_DATA, d); chk("R9 slave pol1 received", d, 8'h99);
    chk("R3 irq in slave mode", irq, 1'b1);
    wr(A_STAT, 8'h00);

    // Disabled port: R11
    wr(A_CTRL, 8'h10);
    wr(A_DATA, 8'h77);
    tog = 0; prev = sck_o;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (sck_o !== prev) begin tog++; prev = sck_o; end
    end
    chk("R11 no sck toggles", tog, 0);
    chk("R11 sck at polarity", sck_o, 1'b1);
    peek(A_STAT, d); chk("R11 not busy, no irq", d[2:1], 2'b00);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule